// File: doc/BRIEF.md
# Frame Alignment Measurement Unit

This block measures how far an external evaluation signal lags the device frame pulse, with half-clock resolution. A host raises a start bit; the block waits for the next frame boundary, counts clock cycles until the first qualifying edge of the evaluation signal, notes whether that edge landed in the high or the low half of the clock period, and posts the result in a 16-bit status word when the following frame boundary arrives.

Two timing conventions are supported, picked by a mode input. In one, frame pulses and evaluation edges are falling transitions. In the other, both are rising transitions. Lowering the start bit clears the status word and aborts any measurement in progress. Another measurement requires the start bit to stay low across a frame boundary before it rises again.

Top module: `frame_align_meas`

## Requirements
- R1: While reset is asserted and after it is released, status reads 0x0000. Bits 15..13 of status are zero at all times.
- R2: A 0→1 change of `start_eval` arms the unit only if `start_eval` was sampled low at a frame edge since the previous rise (or since reset). Otherwise the rise is ignored, and status stays 0x0000 across later frames.
- R3: The first frame edge detected strictly after the arming rise opens the measurement frame. The next frame edge closes it and sets status bit 12. Until then, status bits 12..0 read zero.
- R4: Status bits 10..0 equal the number of rising clock edges from the one that detects the opening frame edge to the one that detects the evaluation edge. An evaluation edge in the first cycle after the opening frame edge reads 1. Values above 2047 read 2047.
- R5: Status bit 11 is 1 when the evaluation transition occurred while the clock was high (between a rising edge and the next falling edge). It is 0 when the transition occurred while the clock was low.
- R6: With `edge_mode`=0, a frame edge is a 1→0 change of `frame_pulse` and an evaluation edge is a 1→0 change of `eval_in`. With `edge_mode`=1, both are 0→1 changes.
- R7: Only the first evaluation edge of the measurement frame is recorded. An evaluation edge detected in the same cycle as the closing frame edge is not recorded. If nothing is recorded, completion reads 0x1000.
- R8: A 1→0 change of `start_eval` makes status read 0x0000 from the next cycle on and aborts a measurement in progress. No later frame edge completes it.
- R9: After completion, while `start_eval` stays high, status holds its value through further frames and evaluation edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; both phases are used for evaluation sampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | Device frame pulse |
| eval_in | input | 1 | Evaluation signal whose lag is measured |
| start_eval | input | 1 | Start bit; rise arms, fall clears |
| edge_mode | input | 1 | 0: falling-edge convention, 1: rising-edge convention |
| status | output | 16 | {3'b0, complete, phase, offset[10:0]} |

## Verification
Two functions can collide: recording an evaluation edge and closing the measurement on the second frame edge. The bench drives the evaluation transition and the closing frame pulse in the same half-cycle, so the unit detects both at one rising clock edge. The expected result is completion with an empty result field, 0x1000. The bench also drops the start bit after an edge has been captured but before the closing frame, and checks that the following frame edges leave status at zero.

// File: rtl/frame_align_meas.sv
module frame_align_meas #(
  parameter int OFF_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_pulse,
  input  logic        eval_in,
  input  logic        start_eval,
  input  logic        edge_mode,
  output logic [15:0] status
);
  localparam logic [OFF_W-1:0] OFF_MAX = '1;
  localparam int PAD_W = 16 - OFF_W - 2;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_MEAS, S_DONE} state_t;
  state_t st;

  logic fp_q, start_q, ev_p, ev_n, low_seen, got, ph;
  logic [OFF_W-1:0] cnt, off;

  wire frame_edge = edge_mode ? (frame_pulse & ~fp_q) : (~frame_pulse & fp_q);
  wire start_rise = start_eval & ~start_q;
  wire start_fall = ~start_eval & start_q;
  wire ev_hi      = (ev_p != edge_mode) && (ev_n == edge_mode);
  wire ev_lo      = (ev_n != edge_mode) && (eval_in == edge_mode);
  wire cfe        = (st == S_DONE);

  assign status = {{PAD_W{1'b0}}, cfe, cfe & ph, cfe ? off : {OFF_W{1'b0}}};

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) ev_n <= 1'b0;
    else        ev_n <= eval_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_q    <= 1'b0;
      start_q <= 1'b0;
      ev_p    <= 1'b0;
      cnt     <= '0;
    end else begin
      fp_q    <= frame_pulse;
      start_q <= start_eval;
      ev_p    <= eval_in;
      if (frame_edge)         cnt <= OFF_W'(1);
      else if (cnt != OFF_MAX) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_seen <= 1'b0;
    else if (start_rise)     low_seen <= 1'b0;
    else if (frame_edge && !start_eval) low_seen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      got <= 1'b0;
      ph  <= 1'b0;
      off <= '0;
    end else if (start_fall) begin
      st  <= S_IDLE;
      got <= 1'b0;
      ph  <= 1'b0;
      off <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (start_rise && low_seen) begin
            st  <= S_ARMED;
            got <= 1'b0;
            ph  <= 1'b0;
            off <= '0;
          end
        S_ARMED:
          if (frame_edge) st <= S_MEAS;
        S_MEAS:
          if (frame_edge) st <= S_DONE;
          else if ((ev_hi || ev_lo) && !got) begin
            got <= 1'b1;
            ph  <= ev_hi;
            off <= cnt;
          end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/frame_align_meas_chk.sv
module frame_align_meas_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_pulse,
  input logic        start_eval,
  input logic        edge_mode,
  input logic [15:0] status
);
  logic fp_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fp_d <= 1'b0;
    else        fp_d <= frame_pulse;

  wire fr_edge = edge_mode ? (frame_pulse & ~fp_d) : (~frame_pulse & fp_d);

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status[15:13] == 3'b000);

  p_result_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !status[12] |-> status[11:0] == 12'h000);

  p_done_on_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[12]) |-> $past(fr_edge) && $past(start_eval));

  p_fall_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_eval && $past(start_eval)) |=> status == 16'h0000);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[12] && start_eval) |=> $stable(status));
endmodule

bind frame_align_meas frame_align_meas_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
  .start_eval(start_eval), .edge_mode(edge_mode), .status(status)
);

// File: tb/frame_align_meas_test.sv
module frame_align_meas_test;
  logic clk = 1'b0, rst_n = 1'b0, fp = 1'b1, ev = 1'b1, start = 1'b0, mode = 1'b0;
  wire [15:0] status;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  frame_align_meas uut (
    .clk(clk), .rst_n(rst_n), .frame_pulse(fp), .eval_in(ev),
    .start_eval(start), .edge_mode(mode), .status(status)
  );

  // {mode, phase, delay[11:0]}
  localparam logic [13:0] VEC [7] = '{
    {1'b0, 1'b1, 12'd1},
    {1'b0, 1'b0, 12'd1},
    {1'b0, 1'b1, 12'd9},
    {1'b0, 1'b0, 12'd17},
    {1'b1, 1'b1, 12'd4},
    {1'b1, 1'b0, 12'd25},
    {1'b0, 1'b1, 12'd2100}
  };

  task automatic tick; @(posedge clk); #2; endtask

  task automatic chk(input string req, input logic [15:0] exp);
    checks++;
    if (status !== exp) begin
      fails++;
      $display("FAIL %s: status=%h expected=%h", req, status, exp);
    end
  endtask

  task automatic frame; tick; fp = mode; tick; fp = ~mode; endtask
  task automatic ev_edge(input logic hi); if (!hi) #4; ev = mode; endtask
  task automatic prime; tick; start = 1'b0; frame; endtask
  task automatic arm; tick; start = 1'b1; tick; endtask
  task automatic drop; tick; start = 1'b0; tick; endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick; tick;
    chk("R1 in reset", 16'h0000);
    rst_n = 1'b1;
    tick;
    chk("R1 after reset", 16'h0000);

    // R2: rise with no low frame since reset is ignored
    arm; frame; tick; ev_edge(1'b1); tick; tick; frame; frame;
    chk("R2 no prior low frame", 16'h0000);
    ev = ~mode;
    drop;

    // R3..R6, R8: vector table
    foreach (VEC[i]) begin
      logic [11:0] d;
      logic [15:0] exp;
      d = VEC[i][11:0];
      mode = VEC[i][13]; fp = ~mode; ev = ~mode;
      tick; tick;
      prime; arm; frame;
      repeat (int'(d) - 1) tick;
      ev_edge(VEC[i][12]);
      repeat (3) tick;
      chk("R3 result hidden before close", 16'h0000);
      ev = ~mode;
      frame;
      exp = {3'b000, 1'b1, VEC[i][12], (d > 12'd2047) ? 11'h7FF : d[10:0]};
      chk("R4 R5 R6 measurement", exp);
      drop;
      chk("R8 clear on fall", 16'h0000);
    end

    mode = 1'b0; fp = 1'b1; ev = 1'b1; tick; tick;

    // R7 first edge only, then R9 hold
    prime; arm; frame;
    repeat (2) tick; ev_edge(1'b1);
    tick; tick; ev = 1'b1; tick; tick; ev_edge(1'b0);
    tick; tick; ev = 1'b1;
    frame;
    chk("R7 first edge only", 16'h1803);
    frame; tick; ev_edge(1'b1); tick; tick; ev = 1'b1; frame; frame;
    chk("R9 no retrigger", 16'h1803);

    // R2: short low pulse without a frame edge
    tick; start = 1'b0; tick; start = 1'b1; tick;
    chk("R8 fall clears done", 16'h0000);
    frame; tick; ev_edge(1'b1); tick; tick; ev = 1'b1; frame; frame;
    chk("R2 short low ignored", 16'h0000);

    // R7 coincidence of eval edge and closing frame edge
    prime; arm; frame;
    repeat (4) tick;
    tick; fp = 1'b0; ev = 1'b0; tick; fp = 1'b1;
    chk("R7 edge on closing frame", 16'h1000);
    ev = 1'b1;
    drop;

    // R8 abort mid-measurement
    prime; arm; frame;
    tick; ev_edge(1'b1); tick; tick;
    start = 1'b0; tick;
    chk("R8 abort", 16'h0000);
    ev = 1'b1; frame; frame;
    chk("R8 aborted stays clear", 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule